// File: doc/BRIEF.md
# Trigger-Stepped Circular Parameter Table

This block keeps a list of wide parameter words, such as oscillator tuning words for frequency hopping or sets of filter weights, that a host writes ahead of time. It presents one word at a time on a registered output. Each rising edge of an asynchronous ranging trigger moves the block to the next word of the list. After the last active entry it returns to the first one. A one-cycle strobe marks every change of the output, so the consuming datapath knows when to take the new word.

The host sets how many entries take part in the rotation through a length register. A bypass control parks the output on a fixed word and makes the block deaf to triggers. The trigger is first brought into the clock domain by a chain of flip-flops. An edge detector follows, so a pulse of any width counts once. The update lands a few clocks after the trigger edge, which is far inside the 4 µs allowed at the 200 MHz system clock.

The control is a four-state machine:
- ST_IDLE waits.
- ST_IDLE goes to ST_BYPASS when bypass is set. This has priority over a trigger.
- ST_IDLE goes to ST_FETCH when a trigger edge arrives.
- ST_FETCH reads the table and always goes to ST_LOAD.
- ST_LOAD drives the word and the strobe, steps the pointer, and returns to ST_IDLE.
- ST_BYPASS returns to ST_IDLE when bypass is cleared.

Top module: `hop_param_table`

## Requirements
- R1: After reset `param_out` is 0, `param_upd` is 0, and the pointer is 0, so the first trigger presents entry 0.
- R2: Each rising edge of `trig_async` produces exactly one update, whatever the pulse width (tested up to 3 µs high). No update happens without a trigger edge or a bypass entry.
- R3: An update puts the table entry at the current pointer on `param_out`, and the pointer then moves on by one.
- R4: The rotation length is written through `len_we`/`len_val` and resets to DEPTH. Once the pointer reaches length-1, or lies beyond it, the next step returns it to 0.
- R5: A length of 0 behaves as 1, so the same entry 0 is repeated. A length above DEPTH behaves as DEPTH.
- R6: With two synchronizer stages, `param_upd` rises on the fifth rising clock edge after the trigger rises. That is between 20 ns and 25 ns at 200 MHz, well under the 4 µs bound.
- R7: `param_upd` is high for exactly one cycle, and `param_out` changes only in a cycle where `param_upd` is high.
- R8: Raising `bypass_en` while idle loads `bypass_val` onto `param_out` with one strobe. While bypass stays set, triggers cause no update, the pointer does not move, and later changes of `bypass_val` do not reach the output.
- R9: After bypass is cleared, the next trigger resumes the rotation at the pointer reached before bypass.
- R10: A host write to an entry changes the word presented the next time that entry is stepped to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Table write enable |
| host_addr | input | ADDR_W | Table entry to write |
| host_wdata | input | DATA_W | Word to write |
| len_we | input | 1 | Load the rotation length |
| len_val | input | ADDR_W+1 | New rotation length |
| bypass_en | input | 1 | Hold a fixed word and ignore triggers |
| bypass_val | input | DATA_W | Word loaded on entering bypass |
| trig_async | input | 1 | Asynchronous ranging trigger |
| param_out | output | DATA_W | Presented parameter word |
| param_upd | output | 1 | One-cycle strobe on every change of `param_out` |

## Verification
The bench builds the block with DEPTH=8, DATA_W=64 and two synchronizer stages. The shallow table lets a few triggers run through the wrap. It also makes a length of 12 an oversize value that must clamp to the full table. The two-stage setting fixes the trigger-to-strobe delay at exactly five clock edges, which the scoreboard measures against the trigger time to the picosecond. The full 64-bit width keeps upper-word patterns in the comparisons.

// File: rtl/hop_pkg.sv
`timescale 1ns/1ps
package hop_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_LOAD,
        ST_BYPASS
    } hop_state_e;
endpackage

// File: rtl/hop_trig_sync.sv
`timescale 1ns/1ps
module hop_trig_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic edge_o
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] chain_q;
    logic                   hist_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
            hist_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[SYNC_STAGES-2:0], async_in};
            hist_q  <= chain_q[TOP];
        end
    end

    assign edge_o = chain_q[TOP] & ~hist_q;

    // R2
    edge_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !edge_o);
endmodule

// File: rtl/hop_table_ram.sv
`timescale 1ns/1ps
module hop_table_ram #(
    parameter int DATA_W = 64,
    parameter int DEPTH  = 128,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
        rdata <= store[raddr];
    end
endmodule

// File: rtl/hop_step_seq.sv
`timescale 1ns/1ps
module hop_step_seq
    import hop_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int DEPTH  = 128,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int LEN_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_edge,
    input  logic              bypass_en,
    input  logic [DATA_W-1:0] bypass_val,
    input  logic              len_we,
    input  logic [LEN_W-1:0]  len_val,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] param_out,
    output logic              param_upd
);
    hop_state_e        state_q, state_d;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  eff_len;
    logic [LEN_W-1:0]  ptr_inc;
    logic [ADDR_W-1:0] ptr_q, ptr_nxt;

    always_comb begin
        if (len_q == '0) begin
            eff_len = LEN_W'(1);
        end else if (len_q > LEN_W'(DEPTH)) begin
            eff_len = LEN_W'(DEPTH);
        end else begin
            eff_len = len_q;
        end
        ptr_inc = {1'b0, ptr_q} + LEN_W'(1);
        ptr_nxt = (ptr_inc >= eff_len) ? '0 : ptr_inc[ADDR_W-1:0];
    end

    assign rd_addr = ptr_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (bypass_en) begin
                    state_d = ST_BYPASS;
                end else if (trig_edge) begin
                    state_d = ST_FETCH;
                end
            end
            ST_FETCH:  state_d = ST_LOAD;
            ST_LOAD:   state_d = ST_IDLE;
            ST_BYPASS: begin
                if (!bypass_en) begin
                    state_d = ST_IDLE;
                end
            end
        endcase
    end

    // outputs, pointer and length
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            param_out <= '0;
            param_upd <= 1'b0;
            ptr_q     <= '0;
            len_q     <= LEN_W'(DEPTH);
        end else begin
            param_upd <= 1'b0;
            if (len_we) begin
                len_q <= len_val;
            end
            unique case (state_q)
                ST_IDLE: begin
                    if (bypass_en) begin
                        param_out <= bypass_val;
                        param_upd <= 1'b1;
                    end
                end
                ST_LOAD: begin
                    param_out <= rd_data;
                    param_upd <= 1'b1;
                    ptr_q     <= ptr_nxt;
                end
                default: ;
            endcase
        end
    end

    // R7
    upd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        param_upd |=> !param_upd);

    // R7
    out_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !param_upd |-> $stable(param_out));

    // R6
    trig_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_edge && state_q == ST_IDLE && !bypass_en) |=> state_q == ST_FETCH);

    // R8
    byp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BYPASS && $past(state_q) == ST_BYPASS) |-> $stable(param_out));

    // R8
    byp_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_BYPASS |=> $stable(ptr_q));

    // R4
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_LOAD |=> (ptr_q == '0 || ptr_q == ADDR_W'($past(ptr_q) + 1'b1)));
endmodule

// File: rtl/hop_param_table.sv
`timescale 1ns/1ps
module hop_param_table #(
    parameter int DATA_W      = 64,
    parameter int DEPTH       = 128,
    parameter int SYNC_STAGES = 2,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int LEN_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              len_we,
    input  logic [LEN_W-1:0]  len_val,
    input  logic              bypass_en,
    input  logic [DATA_W-1:0] bypass_val,
    input  logic              trig_async,
    output logic [DATA_W-1:0] param_out,
    output logic              param_upd
);
    logic              trig_edge;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;

    hop_trig_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (trig_async),
        .edge_o   (trig_edge)
    );

    hop_table_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
        .clk   (clk),
        .we    (host_we),
        .waddr (host_addr),
        .wdata (host_wdata),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    hop_step_seq #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_edge  (trig_edge),
        .bypass_en  (bypass_en),
        .bypass_val (bypass_val),
        .len_we     (len_we),
        .len_val    (len_val),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .param_out  (param_out),
        .param_upd  (param_upd)
    );
endmodule

// File: tb/hop_param_table_tb_top.sv
`timescale 1ns/1ps
module hop_param_table_tb_top;
    localparam int DW  = 64;
    localparam int DEP = 8;
    localparam int AW  = 3;
    localparam int LW  = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_we = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic          len_we = 1'b0;
    logic [LW-1:0] len_val = '0;
    logic          bypass_en = 1'b0;
    logic [DW-1:0] bypass_val = '0;
    logic          trig = 1'b0;
    logic [DW-1:0] param_out;
    logic          upd;

    hop_param_table #(.DATA_W(DW), .DEPTH(DEP), .SYNC_STAGES(2)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .len_we     (len_we),
        .len_val    (len_val),
        .bypass_en  (bypass_en),
        .bypass_val (bypass_val),
        .trig_async (trig),
        .param_out  (param_out),
        .param_upd  (upd)
    );

    always #2.5 clk = ~clk;

    int n_checks = 0;
    int n_errors = 0;

    logic [DW-1:0] ref_tbl [DEP];
    int            m_ptr = 0;
    int            m_len = DEP;

    logic [DW-1:0] q_val [$];
    realtime       q_time [$];
    bit            q_timed [$];
    string         q_req [$];

    task automatic check(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int eff_len(int l);
        if (l == 0) return 1;
        if (l > DEP) return DEP;
        return l;
    endfunction

    task automatic host_write(int a, logic [DW-1:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = AW'(a); host_wdata = d;
        ref_tbl[a] = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic set_len(int l);
        @(negedge clk);
        len_we = 1'b1; len_val = LW'(l);
        m_len = l;
        @(negedge clk);
        len_we = 1'b0;
    endtask

    // driver: raises the trigger and pushes the expected word
    task automatic fire(int hold, string req);
        @(negedge clk);
        #1.3;
        trig = 1'b1;
        if (!bypass_en) begin
            q_val.push_back(ref_tbl[m_ptr]);
            q_time.push_back($realtime);
            q_timed.push_back(1'b1);
            q_req.push_back(req);
            m_ptr = (m_ptr + 1 >= eff_len(m_len)) ? 0 : m_ptr + 1;
        end
        repeat (hold) @(negedge clk);
        trig = 1'b0;
        repeat (150) @(negedge clk);
    endtask

    // monitor: pops expected items as strobes appear
    logic [DW-1:0] last_out = '0;
    bit            last_upd = 1'b0;
    always @(negedge clk) begin : mon
        logic [DW-1:0] v;
        realtime       t;
        bit            timed;
        string         req;
        realtime       lat;
        if (rst_n) begin
            if (upd) begin
                if (q_val.size() == 0) begin
                    check(1'b0, "R2 unexpected strobe", param_out, last_out);
                end else begin
                    v = q_val.pop_front(); t = q_time.pop_front();
                    timed = q_timed.pop_front(); req = q_req.pop_front();
                    check(param_out == v, req, param_out, v);
                    if (timed) begin
                        lat = $realtime - t;
                        check(lat >= 22.5 && lat < 27.5 && lat <= 4000.0,
                              "R6 latency ps", DW'($rtoi(lat * 1000.0)), DW'(27500));
                    end
                end
                if (last_upd) check(1'b0, "R7 strobe wider than one cycle", 1, 0);
            end else if (param_out !== last_out) begin
                check(1'b0, "R7 output moved without strobe", param_out, last_out);
            end
            last_out = param_out;
            last_upd = upd;
        end
    end

    initial begin : watchdog
        #1000000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog R2 actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    logic [DW-1:0] byp_word;

    initial begin : main
        repeat (4) @(negedge clk);
        check(param_out == '0, "R1 reset output", param_out, '0);
        check(upd == 1'b0, "R1 reset strobe", DW'(upd), '0);
        rst_n = 1'b1;

        for (int i = 0; i < DEP; i++) begin
            host_write(i, {32'hFACE_0000 | 32'(i), 32'h0F0F_0F0F ^ (32'(i) * 32'h0101_0101)});
        end
        check(param_out == '0, "R1 no change before first trigger", param_out, '0);

        fire(100, "R1 first trigger gives entry 0");
        for (int i = 0; i < 9; i++) fire(100, "R3 step through table");
        fire(600, "R2 long pulse steps once");

        set_len(3);
        for (int i = 0; i < 4; i++) fire(100, "R4 wrap at programmed length");

        set_len(0);
        for (int i = 0; i < 3; i++) fire(100, "R5 zero length repeats entry 0");

        set_len(12);
        for (int i = 0; i < 9; i++) fire(100, "R5 oversize length clamps");

        host_write(m_ptr, 64'hDEAD_BEEF_0123_4567);
        fire(100, "R10 rewritten entry presented");

        byp_word = 64'h5A5A_1234_C3C3_9876;
        @(negedge clk);
        bypass_val = byp_word;
        bypass_en = 1'b1;
        q_val.push_back(byp_word); q_time.push_back($realtime);
        q_timed.push_back(1'b0); q_req.push_back("R8 bypass word loaded");
        repeat (5) @(negedge clk);
        fire(100, "R8 ignored");
        fire(100, "R8 ignored");
        check(param_out == byp_word, "R8 triggers ignored in bypass", param_out, byp_word);
        bypass_val = 64'h1111_2222_3333_4444;
        repeat (5) @(negedge clk);
        check(param_out == byp_word, "R8 bypass word held", param_out, byp_word);
        bypass_en = 1'b0;
        repeat (3) @(negedge clk);
        fire(100, "R9 rotation resumes at saved pointer");
        fire(100, "R9 rotation continues");

        repeat (20) @(negedge clk);
        check(q_val.size() == 0, "R2 every trigger updated", DW'(q_val.size()), '0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule